// File: doc/BRIEF.md
# Edge-Interval Signal Qualifier

This block decides whether a demodulated serial stream comes from a genuine transmitter or from noise. After a start strobe it times the gap between each pair of consecutive edges of the stream. It then compares every gap against a window. The lower limit and the upper limit of the window are programmed in clock cycles. A gap that lies inside the window lets checking carry on. The first gap outside the window ends the check with a one-cycle fail pulse, which tells the surrounding receiver control to go back to sleep.

A 2-bit selector sets how many bits are checked: 0, 3, 6 or 9. Every bit carries two edges, so the block needs 0, 6, 12 or 18 good gaps. When that many good gaps have been seen in a row, the block issues a one-cycle pass pulse, which tells the receiver to enter receive mode. The block captures the limits and the selector at the start strobe and holds them for the whole check. On a noisy input the first bad gap ends the check, so rejection is quick whatever the selector says.

Top module: `edge_window_check`

## Requirements
- R1: While reset is held and in the first cycle after it, pass_o, fail_o and busy_o are all low.
- R2: With bits_sel_i = 0, a start strobe sampled at clock edge S sets pass_o high in the cycle after S. busy_o stays low.
- R3: bits_sel_i = s (0 to 3) asks for 6*s good intervals. pass_o rises 3 clock edges after the data change that ends the last one. The 3 edges are two synchroniser stages and one edge-detect stage.
- R4: An interval shorter than lim_lo_i gives a fail_o pulse 3 clock edges after the data change that ends it, whatever the selector.
- R5: Once an interval reaches lim_hi_i cycles, fail_o pulses at that point, lim_hi_i cycles after the previous edge was detected. The block does not wait for a further edge. The interval counter never exceeds lim_hi_i.
- R6: The first edge after start only starts timing and is not counted as an interval. If no edge is detected within lim_hi_i cycles of the start edge, fail_o pulses at that point.
- R7: Rising and falling data edges both end an interval.
- R8: pass_o and fail_o are never high together. Each is one cycle wide. busy_o is high from the cycle after an accepted start and low in the cycle where a result pulse is high.
- R9: A start strobe while busy_o is high has no effect.
- R10: Limits and the selector are captured at the start edge. Changes to them during a check do not alter its outcome.
- R11: An interval exactly equal to lim_lo_i is inside the window. An interval exactly equal to lim_hi_i is outside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a check when the block is idle |
| lim_lo_i | input | CW | Shortest accepted interval, in cycles |
| lim_hi_i | input | CW | Interval length, in cycles, that counts as too long |
| bits_sel_i | input | 2 | Number of bits to check: 0, 3, 6 or 9 |
| demod_i | input | 1 | Demodulated data stream, asynchronous |
| pass_o | output | 1 | One-cycle pulse: the stream is accepted |
| fail_o | output | 1 | One-cycle pulse: the stream is rejected |
| busy_o | output | 1 | A check is in progress |

## Verification
A data change made between clock edges m and m+1 is seen as an edge at clock edge m+3, and any decision taken on that edge is visible in cycle m+3. A timeout is decided lim_hi_i edges after the previous edge was detected, or after the start edge. The zero-bit pass appears one cycle after the start is sampled. The driver works out the exact cycle of every result from these rules and queues it together with the result kind. The monitor samples at the falling clock edge, compares both the kind and the cycle number, and treats any pulse it did not expect as a failure.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  localparam int SEL_W = 2;
  localparam int CHK_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_MEAS} ewc_state_e;

  // two edges per bit, bits in steps of three -> six intervals per step
  function automatic logic [CHK_W-1:0] checks_for_sel(input logic [SEL_W-1:0] sel);
    return CHK_W'({3'b000, sel} * 5'd6);
  endfunction
endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic edge_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], din_i};
  end

  // either polarity: compare last synchronised level with the one before
  assign edge_o = sr_q[STAGES-1] ^ sr_q[STAGES];
endmodule

// File: rtl/ewc_timer.sv
module ewc_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [CW-1:0] lim_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (clear_i)       cnt_o <= CW'(1);
    else if (cnt_o < lim_i) cnt_o <= cnt_o + CW'(1);
  end
endmodule

// File: rtl/ewc_ctrl.sv
module ewc_ctrl
  import ewc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CW-1:0]    lo_i,
  input  logic [CW-1:0]    hi_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             edge_i,
  input  logic [CW-1:0]    cnt_i,
  output logic             clear_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             busy_o,
  output logic             meas_o,
  output logic [CW-1:0]    lo_q_o,
  output logic [CW-1:0]    hi_q_o
);
  ewc_state_e       state_q;
  logic [CW-1:0]    lo_q, hi_q;
  logic [CHK_W-1:0] need_q, done_q, need_now;
  logic start_acc, arm_timeout, arm_edge, meas_long, meas_short;
  logic ivl_good, last_good, ivl_bad;

  function automatic logic below_min(input logic [CW-1:0] d, input logic [CW-1:0] lo);
    return d < lo;
  endfunction

  function automatic logic reached_max(input logic [CW-1:0] d, input logic [CW-1:0] hi);
    return d >= hi;
  endfunction

  always_comb begin
    need_now    = checks_for_sel(sel_i);
    start_acc   = (state_q == ST_IDLE) && start_i;
    arm_timeout = (state_q == ST_ARM) && reached_max(cnt_i, hi_q);
    arm_edge    = (state_q == ST_ARM) && !arm_timeout && edge_i;
    meas_long   = (state_q == ST_MEAS) && reached_max(cnt_i, hi_q);
    meas_short  = (state_q == ST_MEAS) && !meas_long && edge_i && below_min(cnt_i, lo_q);
    ivl_good    = (state_q == ST_MEAS) && !meas_long && edge_i && !below_min(cnt_i, lo_q);
    last_good   = ivl_good && (CHK_W'(done_q + 1'b1) == need_q);
    ivl_bad     = arm_timeout || meas_long || meas_short;
    clear_o     = start_acc || arm_edge || ivl_good;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      need_q  <= '0;
      done_q  <= '0;
      pass_o  <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      pass_o <= (start_acc && (need_now == '0)) || last_good;
      fail_o <= ivl_bad;
      unique case (state_q)
        ST_IDLE: if (start_acc) begin
          lo_q   <= lo_i;
          hi_q   <= hi_i;
          need_q <= need_now;
          done_q <= '0;
          if (need_now != '0) state_q <= ST_ARM;
        end
        ST_ARM: begin
          if (arm_timeout)   state_q <= ST_IDLE;
          else if (arm_edge) state_q <= ST_MEAS;
        end
        ST_MEAS: begin
          if (ivl_bad || last_good) state_q <= ST_IDLE;
          else if (ivl_good)        done_q  <= CHK_W'(done_q + 1'b1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign meas_o = (state_q == ST_MEAS);
  assign lo_q_o = lo_q;
  assign hi_q_o = hi_q;
endmodule

// File: rtl/edge_window_check.sv
module edge_window_check
  import ewc_pkg::*;
#(
  parameter int CW      = 16,
  parameter int SYNC_ST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CW-1:0]    lim_lo_i,
  input  logic [CW-1:0]    lim_hi_i,
  input  logic [SEL_W-1:0] bits_sel_i,
  input  logic             demod_i,
  output logic             pass_o,
  output logic             fail_o,
  output logic             busy_o
);
  logic          edge_w, clear_w, meas_w;
  logic [CW-1:0] cnt_w, lo_w, hi_w;

  ewc_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .din_i(demod_i), .edge_o(edge_w)
  );

  ewc_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .clear_i(clear_w), .lim_i(hi_w), .cnt_o(cnt_w)
  );

  ewc_ctrl #(.CW(CW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .lo_i   (lim_lo_i),
    .hi_i   (lim_hi_i),
    .sel_i  (bits_sel_i),
    .edge_i (edge_w),
    .cnt_i  (cnt_w),
    .clear_o(clear_w),
    .pass_o (pass_o),
    .fail_o (fail_o),
    .busy_o (busy_o),
    .meas_o (meas_w),
    .lo_q_o (lo_w),
    .hi_q_o (hi_w)
  );
endmodule

// File: rtl/ewc_checker.sv
module ewc_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pass,
  input logic          fail,
  input logic          busy,
  input logic          meas,
  input logic          edge_s,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lo,
  input logic [CW-1:0] hi
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pass && fail)); // R8
  AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pass |=> !pass); // R8
  AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fail |=> !fail); // R8
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (pass || fail) |-> !busy); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (busy && hi != '0) |-> cnt <= hi); // R5
  AST_LONG_FAILS: assert property (@(posedge clk) disable iff (!rst_n) (meas && cnt >= hi) |=> fail); // R5
  AST_SHORT_FAILS: assert property (@(posedge clk) disable iff (!rst_n) (meas && edge_s && cnt < lo) |=> fail); // R4
  AST_LIMITS_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> ($stable(lo) && $stable(hi))); // R10
  AST_FAIL_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(fail) |-> $past(busy)); // R6
endmodule

bind edge_window_check ewc_checker #(.CW(CW)) u_ewc_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .pass  (pass_o),
  .fail  (fail_o),
  .busy  (busy_o),
  .meas  (meas_w),
  .edge_s(edge_w),
  .cnt   (cnt_w),
  .lo    (lo_w),
  .hi    (hi_w)
);

// File: tb/tb_edge_window_check.sv
module tb_edge_window_check;
  localparam int CW = 16;

  typedef struct {
    bit    is_pass;
    int    cyc;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] lo = '0, hi = '0;
  logic [1:0]    sel = '0;
  logic          data = 1'b0;
  logic          pass, fail, busy;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_window_check #(.CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lim_lo_i(lo), .lim_hi_i(hi),
    .bits_sel_i(sel), .demod_i(data), .pass_o(pass), .fail_o(fail), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: every result pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && (pass || fail)) begin
      check(!busy, "R8", "busy low with result", int'(busy), 0);
      check(!(pass && fail), "R8", "pass and fail together", int'(pass && fail), 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected result pulse at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(pass == e.is_pass, e.req, "result kind (1=pass)", int'(pass), int'(e.is_pass));
        check(cyc == e.cyc, e.req, "result cycle", cyc, e.cyc);
      end
    end
  end

  // first_gap < 0 means no edge at all; disturb pokes start/limits mid-check
  task automatic scenario(input int lo_v, input int hi_v, input int sel_v, input int first_gap,
                          input int gaps[$], input bit disturb, input string req);
    int n, s_edge, t, prev_e, cnt_good, target;
    int toggles[$];
    int last_c, ti;
    bit decided;
    exp_t e;
    @(negedge clk);
    lo = CW'(lo_v); hi = CW'(hi_v); sel = 2'(sel_v); start = 1'b1;
    n = cyc;
    @(negedge clk);
    start = 1'b0;
    s_edge = n + 1;
    target = 6 * sel_v;
    e.req = req;
    decided = 1'b0;
    if (target == 0) begin
      check(!busy, "R2", "busy after zero-bit start", int'(busy), 0);
      e.is_pass = 1'b1; e.cyc = s_edge; exp_q.push_back(e);
      decided = 1'b1;
    end else begin
      check(busy, "R8", "busy after start", int'(busy), 1);
      if (first_gap < 0 || (n + first_gap + 3 - s_edge) >= hi_v) begin
        e.is_pass = 1'b0; e.cyc = s_edge + hi_v; exp_q.push_back(e);
        decided = 1'b1;
      end else begin
        t = n + first_gap;
        toggles.push_back(t);
        prev_e = t + 3;
        cnt_good = 0;
        foreach (gaps[i]) begin
          if (!decided) begin
            if (gaps[i] >= hi_v) begin
              e.is_pass = 1'b0; e.cyc = prev_e + hi_v; exp_q.push_back(e);
              decided = 1'b1;
            end else begin
              t = t + gaps[i];
              toggles.push_back(t);
              if (gaps[i] < lo_v) begin
                e.is_pass = 1'b0; e.cyc = t + 3; exp_q.push_back(e);
                decided = 1'b1;
              end else begin
                cnt_good++;
                prev_e = t + 3;
                if (cnt_good == target) begin
                  e.is_pass = 1'b1; e.cyc = t + 3; exp_q.push_back(e);
                  decided = 1'b1;
                end
              end
            end
          end
        end
        if (!decided) begin
          e.is_pass = 1'b0; e.cyc = prev_e + hi_v; exp_q.push_back(e);
        end
      end
    end
    if (disturb) begin   // R9 R10: would end the check at once if taken
      start = 1'b1; lo = CW'(0); hi = CW'(3); sel = 2'd0;
    end
    last_c = (toggles.size() != 0) ? toggles[toggles.size()-1] : n + 2;
    ti = 0;
    for (int c = n + 2; c <= last_c; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (ti < toggles.size() && toggles[ti] == cyc) begin
        data = ~data;
        ti++;
      end
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic void fill(ref int q[$], input int v, input int k);
    for (int i = 0; i < k; i++) q.push_back(v);
  endfunction

  initial begin
    int g[$];
    repeat (3) @(negedge clk);
    check(!pass && !fail && !busy, "R1", "outputs in reset", int'({pass, fail, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pass && !fail && !busy, "R1", "outputs after reset", int'({pass, fail, busy}), 0);

    g = {}; scenario(4, 10, 0, 2, g, 1'b0, "R2");
    g = {}; fill(g, 6, 6); scenario(4, 10, 1, 2, g, 1'b0, "R3 R6 R7");
    g = {4, 9, 5, 7, 4, 6, 8, 5, 4, 9, 6, 7}; scenario(4, 10, 2, 2, g, 1'b0, "R3 R11");
    g = {}; fill(g, 5, 18); scenario(4, 10, 3, 2, g, 1'b1, "R3 R9 R10");
    g = {6, 6, 3}; scenario(4, 10, 1, 2, g, 1'b0, "R4");
    g = {2}; scenario(4, 10, 3, 2, g, 1'b0, "R4 noise");
    g = {6, 6, 10}; scenario(4, 10, 1, 2, g, 1'b0, "R5 R11");
    g = {}; fill(g, 6, 15); g.push_back(40); scenario(4, 12, 3, 2, g, 1'b0, "R5");
    g = {}; scenario(4, 10, 1, -1, g, 1'b0, "R6 timeout");
    g = {6, 6}; scenario(4, 10, 1, 2, g, 1'b0, "R5 missing edge");

    check(exp_q.size() == 0, "R8", "results still pending", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule